// File: doc/BRIEF.md
# Two-Wire Slave Byte Memory

This block is a serial byte memory that answers as a slave on a two-wire bus made of a clock line and a data line. It samples the bus lines with its own system clock, finds start and stop conditions, and decodes a device-select byte. When that byte matches the fixed type code and the chip-select pins, the block either takes a word address and stores the bytes that follow, or shifts out stored bytes. It pulls the data line low to acknowledge each byte it receives.

The address is 9 bits wide. The upper bit is a page bit and travels in the device-select byte. The lower 8 bits come as a separate word-address byte. Writes are committed during the bus transfer itself, so the block has no busy period and acknowledges a new transaction straight after a stop. The data line is open-drain: the block only ever pulls it low, and it never drives the clock line.

Top module: `twowire_bytemem`

## Requirements
- R1: After reset the block is idle, keeps `sda_pull_o` at 0 and waits for a start condition.
- R2: The device-select byte is sent MSB first. Bits 7:4 must equal 1010 and bits 3:2 must equal `sel_pins_i[1:0]`. Bit 1 is the page bit and bit 0 is the direction (1 means read). On a match the block pulls SDA low during the ninth clock. On a mismatch it leaves SDA released for that byte and for every following byte until the next start, and it writes nothing.
- R3: In a write transaction the byte after the device-select byte is the word address. The byte address is {page bit, word address}, so the two pages hold separate data.
- R4: Every data byte received in a write is stored at the current address and acknowledged. A new transaction issued right after a stop is acknowledged with no busy period.
- R5: In a read, stored bytes leave MSB first and change only while SCL is low. A low level from the master on the ninth clock asks for another byte. A high level ends the transfer, and SDA then stays released.
- R6: After each byte written or read, the 9-bit address advances by one and wraps from 0x1FF to 0x000.
- R7: A read with no word address starts at the internal address, which is the byte after the last one accessed. The page bit of the device-select byte replaces the page bit of that address.
- R8: A start condition seen in the middle of a transfer restarts device-select decoding (repeated start), so a write of the address followed by a read gives a random-address read.
- R9: A stop condition in any state returns the block to idle. A byte cut off by a stop before all 8 bits arrive is not written, and bytes already committed stay intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus lines |
| rst_n | input | 1 | Active-low reset (power-on reset) |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| sel_pins_i | input | 2 | Chip-select straps compared with device-select bits 3:2 |

## Verification
The bench runs a master model that writes short bursts to both pages and reads them back in three ways: a random read (address write, repeated start, then read), a current-address read, and a read that crosses 0x1FF. The page test tells the page bit in the device-select byte apart from the word address. The wrap test shows whether the counter covers all 9 bits or only 8. Device-select bytes with a wrong chip-select or a wrong type code, followed by data bytes, check that a non-addressed block stays silent and leaves the memory alone. A stop cut into the middle of a byte checks that no partial byte is committed.

// File: rtl/tw_mem_pkg.sv
package tw_mem_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEVSEL,
      ST_ACK_DEV,
      ST_WADDR,
      ST_ACK_WA,
      ST_WDATA,
      ST_ACK_WD,
      ST_RDATA,
      ST_RACK
   } tw_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } tw_bus_ev_t;

endpackage

// File: rtl/tw_cond_det.sv
module tw_cond_det
   import tw_mem_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output tw_bus_ev_t ev_o
);

   logic [SYNC_STAGES-1:0] scl_sh;
   logic [SYNC_STAGES-1:0] sda_sh;
   logic                   scl_q;
   logic                   sda_q;
   logic                   scl_s;
   logic                   sda_s;

   initial assert (SYNC_STAGES >= 1 && SYNC_STAGES <= 4)
      else $error("tw_cond_det: SYNC_STAGES out of range");

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= scl_i;
               sda_sh <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
               sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   assign scl_s = scl_sh[SYNC_STAGES-1];
   assign sda_s = sda_sh[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      ev_o.start = scl_s & scl_q & sda_q & ~sda_s;
      ev_o.stop  = scl_s & scl_q & ~sda_q & sda_s;
      ev_o.rise  = scl_s & ~scl_q;
      ev_o.fall  = ~scl_s & scl_q;
      ev_o.sda   = sda_s;
   end

endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] mem [DEPTH];

   initial assert (DEPTH <= 4096)
      else $error("tw_mem_array: depth too large");

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   assign rdata_o = mem[raddr_i];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> mem[$past(waddr_i)] == $past(wdata_i)); // R4

endmodule

// File: rtl/twowire_bytemem.sv
module twowire_bytemem
   import tw_mem_pkg::*;
#(
   parameter int         PAGE_W      = 1,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_TYPE    = 4'b1010,
   localparam int        CS_W        = 3 - PAGE_W,
   localparam int        ADDR_W      = 8 + PAGE_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_i,
   input  logic            sda_i,
   output logic            sda_pull_o,
   input  logic [CS_W-1:0] sel_pins_i
);

   localparam int BYTE_W = 8;

   tw_bus_ev_t        ev;
   tw_state_e         state;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;
   logic [ADDR_W-1:0] addr_q;
   logic              rw_q;
   logic              mack_q;
   logic              oe_q;
   logic              byte_done;
   logic              dev_hit;
   logic              we;
   logic [BYTE_W-1:0] rdata;

   initial assert (PAGE_W >= 1 && PAGE_W <= 2)
      else $error("twowire_bytemem: PAGE_W must be 1 or 2");

   tw_cond_det #(.SYNC_STAGES(SYNC_STAGES)) cond_i (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev_o  (ev)
   );

   assign byte_done = ev.fall && (bit_cnt == 4'd8);
   assign dev_hit   = (rx_sh[7:4] == DEV_TYPE) && (rx_sh[3:PAGE_W+1] == sel_pins_i);
   assign we        = (state == ST_WDATA) && byte_done;

   tw_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) mem_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we),
      .waddr_i (addr_q),
      .wdata_i (rx_sh),
      .raddr_i (addr_q),
      .rdata_o (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         addr_q  <= '0;
         rw_q    <= 1'b0;
         mack_q  <= 1'b1;
         oe_q    <= 1'b0;
      end else if (ev.start) begin
         state   <= ST_DEVSEL;
         bit_cnt <= '0;
         oe_q    <= 1'b0;
      end else if (ev.stop) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         oe_q    <= 1'b0;
      end else begin
         case (state)
            ST_DEVSEL, ST_WADDR, ST_WDATA: begin
               if (ev.rise) begin
                  rx_sh   <= {rx_sh[BYTE_W-2:0], ev.sda};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (byte_done) begin
                  if (state == ST_DEVSEL) begin
                     if (dev_hit) begin
                        oe_q                 <= 1'b1;
                        rw_q                 <= rx_sh[0];
                        addr_q[ADDR_W-1:8]   <= rx_sh[PAGE_W:1];
                        state                <= ST_ACK_DEV;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else if (state == ST_WADDR) begin
                     addr_q[7:0] <= rx_sh;
                     oe_q        <= 1'b1;
                     state       <= ST_ACK_WA;
                  end else begin
                     addr_q <= addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
                     oe_q   <= 1'b1;
                     state  <= ST_ACK_WD;
                  end
               end
            end
            ST_ACK_DEV: begin
               if (ev.fall) begin
                  bit_cnt <= '0;
                  if (rw_q) begin
                     tx_sh <= rdata;
                     oe_q  <= ~rdata[BYTE_W-1];
                     state <= ST_RDATA;
                  end else begin
                     oe_q  <= 1'b0;
                     state <= ST_WADDR;
                  end
               end
            end
            ST_ACK_WA, ST_ACK_WD: begin
               if (ev.fall) begin
                  bit_cnt <= '0;
                  oe_q    <= 1'b0;
                  state   <= ST_WDATA;
               end
            end
            ST_RDATA: begin
               if (ev.rise) begin
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (ev.fall) begin
                  if (bit_cnt == 4'd8) begin
                     oe_q   <= 1'b0;
                     addr_q <= addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
                     state  <= ST_RACK;
                  end else begin
                     oe_q  <= ~tx_sh[BYTE_W-2];
                     tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                  end
               end
            end
            ST_RACK: begin
               if (ev.rise) begin
                  mack_q <= ev.sda;
               end else if (ev.fall) begin
                  bit_cnt <= '0;
                  if (!mack_q) begin
                     tx_sh <= rdata;
                     oe_q  <= ~rdata[BYTE_W-1];
                     state <= ST_RDATA;
                  end else begin
                     oe_q  <= 1'b0;
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_pull_o = oe_q;

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_pull_o); // R1

   AST_ACK_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state inside {ST_ACK_DEV, ST_ACK_WA, ST_ACK_WD}) |-> sda_pull_o); // R2

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> addr_q == ADDR_W'($past(addr_q) + 1'b1)); // R6

   AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      ev.start |=> (state == ST_DEVSEL) && !sda_pull_o); // R8

   AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      ev.stop |=> state == ST_IDLE); // R9

endmodule

// File: tb/twowire_bytemem_tb_top.sv
module twowire_bytemem_tb_top;

   localparam int CLK_P = 10;
   localparam logic [1:0] SEL = 2'b10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus;
   logic dut_pull;

   int n_checks = 0;
   int n_bad = 0;

   string      req_q[$];
   logic [7:0] val_q[$];
   logic [7:0] obs_val;
   event       obs_ev;

   always #(CLK_P/2) clk = ~clk;

   assign sda_bus = sda_m & ~dut_pull;

   twowire_bytemem dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_bus),
      .sda_pull_o (dut_pull),
      .sel_pins_i (SEL)
   );

   function automatic logic [7:0] dev(input logic [1:0] cs, input logic pg, input logic rd);
      return {4'b1010, cs, pg, rd};
   endfunction

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   // scoreboard monitor: pops one expected item per observed result
   initial begin
      forever begin
         @(obs_ev);
         if (val_q.size() == 0) begin
            chk("scoreboard-empty", obs_val, 8'hxx);
         end else begin
            chk(req_q.pop_front(), obs_val, val_q.pop_front());
         end
      end
   end

   task automatic push_exp(input string req, input logic [7:0] v);
      req_q.push_back(req);
      val_q.push_back(v);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_c();
      sda_m = 1'b1;
      wait_n(4);
      scl_m = 1'b1;
      wait_n(8);
      sda_m = 1'b0;
      wait_n(8);
      scl_m = 1'b0;
   endtask

   task automatic stop_c();
      wait_n(4);
      sda_m = 1'b0;
      wait_n(4);
      scl_m = 1'b1;
      wait_n(8);
      sda_m = 1'b1;
      wait_n(8);
   endtask

   task automatic bit_out(input logic b);
      wait_n(4);
      sda_m = b;
      wait_n(4);
      scl_m = 1'b1;
      wait_n(8);
      scl_m = 1'b0;
   endtask

   task automatic bit_in(output logic b);
      wait_n(4);
      sda_m = 1'b1;
      wait_n(4);
      scl_m = 1'b1;
      wait_n(4);
      b = sda_bus;
      wait_n(4);
      scl_m = 1'b0;
   endtask

   // driver: sends one byte, expects ack level (0 = acked, 1 = released)
   task automatic wr_byte(input logic [7:0] d, input logic exp_rel, input string req);
      logic a;
      push_exp(req, {7'd0, exp_rel});
      for (int i = 7; i >= 0; i--) bit_out(d[i]);
      bit_in(a);
      obs_val = {7'd0, a};
      ->obs_ev;
   endtask

   task automatic rd_byte(input logic [7:0] exp, input logic more, input string req);
      logic [7:0] d;
      logic b;
      push_exp(req, exp);
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         d[i] = b;
      end
      obs_val = d;
      ->obs_ev;
      bit_out(!more);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_checks + 1, n_bad);
      $finish;
   end

   initial begin
      wait_n(5);
      rst_n = 1'b1;
      wait_n(5);
      chk("R1 idle release", {7'd0, dut_pull}, 8'h00);

      // R4 write burst page 0 at 0x10
      start_c();
      wr_byte(dev(SEL, 1'b0, 1'b0), 1'b0, "R2 devsel ack");
      wr_byte(8'h10, 1'b0, "R3 word addr ack");
      wr_byte(8'h11, 1'b0, "R4 data ack");
      wr_byte(8'h22, 1'b0, "R4 data ack");
      wr_byte(8'h33, 1'b0, "R4 data ack");
      wr_byte(8'h44, 1'b0, "R4 data ack");
      stop_c();

      // R4 back-to-back transaction, page 1 same word address (R3)
      start_c();
      wr_byte(dev(SEL, 1'b1, 1'b0), 1'b0, "R4 no busy after stop");
      wr_byte(8'h10, 1'b0, "R3 word addr ack");
      wr_byte(8'hA5, 1'b0, "R4 data ack");
      wr_byte(8'h5A, 1'b0, "R4 data ack");
      stop_c();

      // R8 random read page 0 via repeated start, R5/R6 sequential
      start_c();
      wr_byte(dev(SEL, 1'b0, 1'b0), 1'b0, "R2 devsel ack");
      wr_byte(8'h10, 1'b0, "R3 word addr ack");
      start_c();
      wr_byte(dev(SEL, 1'b0, 1'b1), 1'b0, "R8 repeated start devsel");
      rd_byte(8'h11, 1'b1, "R5 read byte0");
      rd_byte(8'h22, 1'b1, "R6 read increment");
      rd_byte(8'h33, 1'b0, "R6 read increment");
      wait_n(4);
      chk("R5 release after nack", {7'd0, dut_pull}, 8'h00);
      stop_c();

      // R7 current-address read continues at 0x013
      start_c();
      wr_byte(dev(SEL, 1'b0, 1'b1), 1'b0, "R2 devsel ack");
      rd_byte(8'h44, 1'b0, "R7 current address");
      stop_c();

      // R3 page 1 holds its own data
      start_c();
      wr_byte(dev(SEL, 1'b1, 1'b0), 1'b0, "R2 devsel ack");
      wr_byte(8'h10, 1'b0, "R3 word addr ack");
      start_c();
      wr_byte(dev(SEL, 1'b1, 1'b1), 1'b0, "R8 repeated start devsel");
      rd_byte(8'hA5, 1'b1, "R3 page1 data");
      rd_byte(8'h5A, 1'b0, "R3 page1 data");
      stop_c();

      // R6 wrap from 0x1FF to 0x000 on write and read
      start_c();
      wr_byte(dev(SEL, 1'b1, 1'b0), 1'b0, "R2 devsel ack");
      wr_byte(8'hFF, 1'b0, "R3 word addr ack");
      wr_byte(8'hC3, 1'b0, "R4 data ack");
      wr_byte(8'h3C, 1'b0, "R6 write wrap ack");
      stop_c();
      start_c();
      wr_byte(dev(SEL, 1'b1, 1'b0), 1'b0, "R2 devsel ack");
      wr_byte(8'hFF, 1'b0, "R3 word addr ack");
      start_c();
      wr_byte(dev(SEL, 1'b1, 1'b1), 1'b0, "R8 repeated start devsel");
      rd_byte(8'hC3, 1'b1, "R6 top byte");
      rd_byte(8'h3C, 1'b0, "R6 read wrap");
      stop_c();

      // R2 chip-select mismatch: no ack, data ignored
      start_c();
      wr_byte(dev(2'b01, 1'b0, 1'b0), 1'b1, "R2 cs mismatch nack");
      wr_byte(8'h00, 1'b1, "R2 ignored byte");
      wr_byte(8'hEE, 1'b1, "R2 ignored byte");
      stop_c();
      // R2 type mismatch
      start_c();
      wr_byte({4'b1011, SEL, 2'b00}, 1'b1, "R2 type mismatch nack");
      wr_byte(8'h00, 1'b1, "R2 ignored byte");
      wr_byte(8'hEE, 1'b1, "R2 ignored byte");
      stop_c();
      start_c();
      wr_byte(dev(SEL, 1'b0, 1'b0), 1'b0, "R2 devsel ack");
      wr_byte(8'h00, 1'b0, "R3 word addr ack");
      start_c();
      wr_byte(dev(SEL, 1'b0, 1'b1), 1'b0, "R8 repeated start devsel");
      rd_byte(8'h3C, 1'b0, "R2 memory untouched by mismatch");
      stop_c();

      // R9 stop mid-byte: partial byte not committed
      start_c();
      wr_byte(dev(SEL, 1'b0, 1'b0), 1'b0, "R2 devsel ack");
      wr_byte(8'h20, 1'b0, "R3 word addr ack");
      wr_byte(8'h77, 1'b0, "R4 data ack");
      wr_byte(8'h88, 1'b0, "R4 data ack");
      stop_c();
      start_c();
      wr_byte(dev(SEL, 1'b0, 1'b0), 1'b0, "R2 devsel ack");
      wr_byte(8'h21, 1'b0, "R3 word addr ack");
      for (int i = 0; i < 4; i++) bit_out(1'b1);
      stop_c();
      chk("R9 idle after stop", {7'd0, dut_pull}, 8'h00);
      start_c();
      wr_byte(dev(SEL, 1'b0, 1'b0), 1'b0, "R9 ack after aborted byte");
      wr_byte(8'h20, 1'b0, "R3 word addr ack");
      start_c();
      wr_byte(dev(SEL, 1'b0, 1'b1), 1'b0, "R8 repeated start devsel");
      rd_byte(8'h77, 1'b1, "R9 committed byte kept");
      rd_byte(8'h88, 1'b0, "R9 partial byte dropped");
      stop_c();

      wait_n(4);
      chk("R1 idle at end", {7'd0, dut_pull}, 8'h00);
      if (val_q.size() != 0) chk("scoreboard-leftover", 8'(val_q.size()), 8'h00);

      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

endmodule